// File: doc/BRIEF.md
# Queue Status and Interrupt Aggregator

This block gathers the condition flags of 64 hardware queues into a small bank of readable status words and turns chosen flag transitions into two interrupt lines. The queues fall into two groups. The 32 lower queues each report four flags: empty, nearly empty, nearly full and full. The 32 upper queues each report only nearly empty and full. A separate two-bit underflow/overflow indication per lower queue is also collected for readback. The queue storage itself lives elsewhere; this block only sees the flag vectors.

Each lower queue has a 3-bit interrupt source code that picks one of its four flags, either as is or inverted. The upper group always interrupts on nearly empty. A rising source condition latches a bit in the group's interrupt status word. Software clears a latched bit by writing a one to it. A group's interrupt line is high when any latched bit is also enabled in that group's enable word.

Source codes are written one queue at a time through a field-write port, so no read-modify-write of a packed word is needed. Queue 0's field is narrower: bit 3 of select word 0 is a separate control flag with its own set strobe.

Top module: `qirq_agg`

## Requirements
- R1: Lower status words at addresses 0 to 3 hold queue q in word q/8 at bits (q mod 8)*4+3 down to (q mod 8)*4, with empty at bit 0, nearly empty at bit 1, nearly full at bit 2 and full at bit 3. A flag change shows in the status one cycle after it is sampled.
- R2: After reset: the lower status words read 0x33333333, the underflow/overflow words read 0, the upper nearly-empty word (address 6) reads all ones, the upper full word (address 7) reads 0, both enable words and both interrupt status words read 0, and both interrupt lines are low.
- R3: Underflow/overflow words at addresses 4 and 5 hold 16 queues each, two bits per queue at bits (q mod 16)*2+1 down to (q mod 16)*2, with underflow in the low bit and overflow in the high bit.
- R4: Source codes 0 to 7 select empty, nearly empty, nearly full, full, not empty, not nearly empty, not nearly full, not full. When the selected condition of lower queue q goes from false to true, bit q of the lower interrupt status word (address 14) becomes one.
- R5: A field write sets only queue q's 4-bit field in the select words (addresses 8 to 11, word q/8, bits (q mod 8)*4+3 down to (q mod 8)*4). Every other field keeps its value.
- R6: A field write to queue 0 changes only bits 2:0 of select word 0. Bit 3 of that word is set only by the control-set strobe and stays set until reset.
- R7: Bit q-32 of the upper interrupt status word (address 15) becomes one when that queue's nearly-empty flag rises. A change of the upper full flag sets no bit.
- R8: Writing a word to an interrupt status address clears the bits where the word holds one and leaves the other bits unchanged.
- R9: The lower and upper interrupt lines are high one cycle after some interrupt status bit and the matching enable bit (address 12 lower, address 13 upper) are both one, and low otherwise.
- R10: Interrupts are edge based. A condition that stays true does not set its status bit again after the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_flags | input | 128 | Lower-group flags, 4 per queue, nibble q holds {full, nearly full, nearly empty, empty} |
| uo_flags | input | 64 | Lower-group underflow (low bit) and overflow (high bit), 2 per queue |
| up_ne | input | 32 | Upper-group nearly-empty flags, bit q-32 |
| up_full | input | 32 | Upper-group full flags, bit q-32 |
| fld_wr | input | 1 | Field-write strobe for one queue's source select |
| fld_q | input | 5 | Lower queue index for the field write |
| fld_val | input | 4 | New select field value |
| ctl_set | input | 1 | Sets the control bit (bit 3 of select word 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of the word at reg_addr |
| irq_lo | output | 1 | Lower-group interrupt line |
| irq_up | output | 1 | Upper-group interrupt line |

## Verification
The hardest case to reach from the ports is an interrupt from an inverted source. The queue must first sit with the chosen flag set, so the inverted condition is false, and only then may the flag drop. Changing a select code can itself create a rising condition. So the bench sets each select code while the condition is false, clears the status word, and then moves one flag. It then checks that exactly one status bit appeared. The bench also holds a condition true across a clear, to show that a level does not set the bit again.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int WORD_W = 32;

  // flag positions inside a lower-group status nibble
  localparam int FLG_EMPTY  = 0;
  localparam int FLG_NEMPTY = 1;
  localparam int FLG_NFULL  = 2;
  localparam int FLG_FULL   = 3;

  localparam logic [3:0] LOW_RST_NIB = 4'b0011;

  // register word addresses
  localparam logic [3:0] A_LSTAT  = 4'h0;  // 0..3
  localparam logic [3:0] A_UO     = 4'h4;  // 4..5
  localparam logic [3:0] A_UNE    = 4'h6;
  localparam logic [3:0] A_UFULL  = 4'h7;
  localparam logic [3:0] A_SEL    = 4'h8;  // 8..11
  localparam logic [3:0] A_IE_LO  = 4'hC;
  localparam logic [3:0] A_IE_UP  = 4'hD;
  localparam logic [3:0] A_ISR_LO = 4'hE;
  localparam logic [3:0] A_ISR_UP = 4'hF;

  // source code: bits 1:0 pick the flag, bit 2 inverts it
  function automatic logic src_hit(input logic [3:0] nib, input logic [2:0] code);
    return nib[code[1:0]] ^ code[2];
  endfunction
endpackage

// File: rtl/qirq_status.sv
module qirq_status #(
  parameter int NUM_LOW = 32,
  parameter int NUM_UP  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOW*4-1:0] low_flags,
  input  logic [NUM_LOW*2-1:0] uo_flags,
  input  logic [NUM_UP-1:0]    up_ne,
  input  logic [NUM_UP-1:0]    up_full,
  output logic [NUM_LOW*4-1:0] low_stat,
  output logic [NUM_LOW*2-1:0] uo_stat,
  output logic [NUM_UP-1:0]    une_stat,
  output logic [NUM_UP-1:0]    ufull_stat
);
  import qirq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_stat   <= {NUM_LOW{LOW_RST_NIB}};
      uo_stat    <= '0;
      une_stat   <= '1;
      ufull_stat <= '0;
    end else begin
      low_stat   <= low_flags;
      uo_stat    <= uo_flags;
      une_stat   <= up_ne;
      ufull_stat <= up_full;
    end
  end

  // R2: the first cycle after reset shows the reset pattern
  a_r2_status_reset: assert property (@(posedge clk)
    $past(rst) |-> (low_stat == {NUM_LOW{LOW_RST_NIB}} && une_stat == '1 && ufull_stat == '0));
endmodule

// File: rtl/qirq_sel_bank.sv
module qirq_sel_bank #(
  parameter int NUM_LOW = 32,
  parameter int QW      = $clog2(NUM_LOW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fld_wr,
  input  logic [QW-1:0]        fld_q,
  input  logic [3:0]           fld_val,
  input  logic                 ctl_set,
  output logic [NUM_LOW*4-1:0] sel_flat
);
  function automatic logic [NUM_LOW*4-1:0] fmask(input logic [QW-1:0] q);
    return {{(NUM_LOW*4-4){1'b0}}, 4'hF} << (32'(q) * 4);
  endfunction

  logic ctl_bit;

  always_ff @(posedge clk) begin
    if (rst) ctl_bit <= 1'b0;
    else if (ctl_set) ctl_bit <= 1'b1;
  end

  for (genvar q = 0; q < NUM_LOW; q++) begin : g_fld
    if (q == 0) begin : g_narrow
      logic [2:0] code;
      always_ff @(posedge clk) begin
        if (rst) code <= '0;
        else if (fld_wr && fld_q == QW'(q)) code <= fld_val[2:0];
      end
      assign sel_flat[3:0] = {ctl_bit, code};
    end else begin : g_full
      logic [3:0] code;
      always_ff @(posedge clk) begin
        if (rst) code <= '0;
        else if (fld_wr && fld_q == QW'(q)) code <= fld_val;
      end
      assign sel_flat[q*4 +: 4] = code;
    end
  end

  // R5: a field write leaves all other fields as they were
  a_r5_field_isolated: assert property (@(posedge clk) disable iff (rst)
    (fld_wr && !ctl_set) |=> (((sel_flat ^ $past(sel_flat)) & ~fmask($past(fld_q))) == '0));
  // R6: a field write to queue 0 never touches the control bit
  a_r6_ctl_untouched: assert property (@(posedge clk) disable iff (rst)
    (fld_wr && fld_q == '0 && !ctl_set) |=> $stable(sel_flat[3]));
  // R6: the control bit is sticky
  a_r6_ctl_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(sel_flat[3]) |-> sel_flat[3]);
endmodule

// File: rtl/qirq_latch.sv
module qirq_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] isr,
  output logic         irq
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '1;
      isr  <= '0;
      irq  <= 1'b0;
    end else begin
      prev <= cond;
      isr  <= (isr & ~clr) | (cond & ~prev);
      irq  <= |(isr & ie);
    end
  end

  // R10: a newly set status bit always follows a rising condition
  a_r10_edge_only: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) & ~($past(cond) & ~$past(cond, 2))) == '0);
  // R9: with nothing enabled the line is low in the next cycle
  a_r9_masked_low: assert property (@(posedge clk) disable iff (rst)
    (ie == '0) |=> !irq);
  // R8: a cleared bit with a steady condition stays cleared
  a_r8_clear_holds: assert property (@(posedge clk) disable iff (rst)
    ((clr & isr) != '0 && $stable(cond)) |=> ((isr & $past(clr & isr)) == '0));
endmodule

// File: rtl/qirq_agg.sv
module qirq_agg #(
  parameter int NUM_LOW = 32,
  parameter int NUM_UP  = 32,
  localparam int QW     = $clog2(NUM_LOW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOW*4-1:0] low_flags,
  input  logic [NUM_LOW*2-1:0] uo_flags,
  input  logic [NUM_UP-1:0]    up_ne,
  input  logic [NUM_UP-1:0]    up_full,
  input  logic                 fld_wr,
  input  logic [QW-1:0]        fld_q,
  input  logic [3:0]           fld_val,
  input  logic                 ctl_set,
  input  logic                 reg_wr,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq_lo,
  output logic                 irq_up
);
  import qirq_pkg::*;

  localparam int PAD_LOW = 4 * WORD_W;  // four status words
  localparam int PAD_UO  = 2 * WORD_W;  // two underflow/overflow words

  logic [NUM_LOW*4-1:0] low_stat, sel_flat;
  logic [NUM_LOW*2-1:0] uo_stat;
  logic [NUM_UP-1:0]    une_stat, ufull_stat;
  logic [NUM_LOW-1:0]   cond_lo, isr_lo, ie_lo, clr_lo;
  logic [NUM_UP-1:0]    isr_up, ie_up, clr_up;

  qirq_status #(.NUM_LOW(NUM_LOW), .NUM_UP(NUM_UP)) u_status (
    .clk(clk), .rst(rst), .low_flags(low_flags), .uo_flags(uo_flags),
    .up_ne(up_ne), .up_full(up_full), .low_stat(low_stat), .uo_stat(uo_stat),
    .une_stat(une_stat), .ufull_stat(ufull_stat));

  qirq_sel_bank #(.NUM_LOW(NUM_LOW), .QW(QW)) u_sel (
    .clk(clk), .rst(rst), .fld_wr(fld_wr), .fld_q(fld_q), .fld_val(fld_val),
    .ctl_set(ctl_set), .sel_flat(sel_flat));

  for (genvar q = 0; q < NUM_LOW; q++) begin : g_src
    assign cond_lo[q] = src_hit(low_stat[q*4 +: 4], sel_flat[q*4 +: 3]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_lo <= '0;
      ie_up <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_IE_LO) ie_lo <= reg_wdata[NUM_LOW-1:0];
      if (reg_addr == A_IE_UP) ie_up <= reg_wdata[NUM_UP-1:0];
    end
  end

  assign clr_lo = (reg_wr && reg_addr == A_ISR_LO) ? reg_wdata[NUM_LOW-1:0] : '0;
  assign clr_up = (reg_wr && reg_addr == A_ISR_UP) ? reg_wdata[NUM_UP-1:0] : '0;

  qirq_latch #(.N(NUM_LOW)) u_lat_lo (
    .clk(clk), .rst(rst), .cond(cond_lo), .clr(clr_lo), .ie(ie_lo),
    .isr(isr_lo), .irq(irq_lo));

  // upper group source is fixed to nearly empty
  qirq_latch #(.N(NUM_UP)) u_lat_up (
    .clk(clk), .rst(rst), .cond(une_stat), .clr(clr_up), .ie(ie_up),
    .isr(isr_up), .irq(irq_up));

  logic [PAD_LOW-1:0] low_pad, sel_pad;
  logic [PAD_UO-1:0]  uo_pad;
  assign low_pad = PAD_LOW'(low_stat);
  assign sel_pad = PAD_LOW'(sel_flat);
  assign uo_pad  = PAD_UO'(uo_stat);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        4'h0, 4'h1, 4'h2, 4'h3: reg_rdata <= low_pad[reg_addr[1:0]*WORD_W +: WORD_W];
        4'h4, 4'h5:             reg_rdata <= uo_pad[reg_addr[0]*WORD_W +: WORD_W];
        A_UNE:                  reg_rdata <= WORD_W'(une_stat);
        A_UFULL:                reg_rdata <= WORD_W'(ufull_stat);
        4'h8, 4'h9, 4'hA, 4'hB: reg_rdata <= sel_pad[reg_addr[1:0]*WORD_W +: WORD_W];
        A_IE_LO:                reg_rdata <= WORD_W'(ie_lo);
        A_IE_UP:                reg_rdata <= WORD_W'(ie_up);
        A_ISR_LO:               reg_rdata <= WORD_W'(isr_lo);
        default:                reg_rdata <= WORD_W'(isr_up);
      endcase
    end
  end

  // R7: upper status bits only appear on a nearly-empty rise
  a_r7_upper_source: assert property (@(posedge clk) disable iff (rst)
    ((isr_up & ~$past(isr_up)) & ~$past(une_stat)) == '0);
  // R9: a line only rises when some latched bit was enabled
  a_r9_line_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_lo) |-> ($past(isr_lo) != '0 && $past(ie_lo) != '0));
endmodule

// File: tb/qirq_agg_bench.sv
module qirq_agg_bench;
  logic         clk = 0;
  logic         rst = 1;
  logic [127:0] low_flags;
  logic [63:0]  uo_flags = '0;
  logic [31:0]  up_ne = '1, up_full = '0;
  logic         fld_wr = 0, ctl_set = 0, reg_wr = 0;
  logic [4:0]   fld_q = '0;
  logic [3:0]   fld_val = '0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         irq_lo, irq_up;
  int total = 0, bad = 0;

  initial low_flags = {32{4'h3}};
  always #5 clk = ~clk;

  qirq_agg u_qirq_agg (
    .clk(clk), .rst(rst), .low_flags(low_flags), .uo_flags(uo_flags),
    .up_ne(up_ne), .up_full(up_full), .fld_wr(fld_wr), .fld_q(fld_q),
    .fld_val(fld_val), .ctl_set(ctl_set), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo), .irq_up(irq_up));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic fwr(input int q, input logic [3:0] v);
    @(negedge clk);
    fld_wr = 1; fld_q = 5'(q); fld_val = v;
    @(negedge clk);
    fld_wr = 0;
  endtask

  task automatic set_nib(input int q, input logic [3:0] v);
    @(negedge clk);
    low_flags[q*4 +: 4] = v;
    idle(4);
  endtask

  task automatic t_reset;
    rd(4'h0, 32'h33333333, "R2 lstat0");
    rd(4'h3, 32'h33333333, "R2 lstat3");
    rd(4'h4, 32'h0, "R2 uo");
    rd(4'h6, 32'hFFFFFFFF, "R2 une");
    rd(4'h7, 32'h0, "R2 ufull");
    rd(4'hC, 32'h0, "R2 ie");
    rd(4'hE, 32'h0, "R2 isr lo");
    rd(4'hF, 32'h0, "R2 isr up");
    check("R2 irq lines", {30'b0, irq_up, irq_lo}, 32'h0);
  endtask

  task automatic t_status;
    @(negedge clk);
    low_flags[9*4 +: 4] = 4'hA;
    low_flags[0 +: 4]   = 4'h5;
    uo_flags[17*2 +: 2] = 2'b10;
    up_full[5] = 1'b1;
    idle(2);
    rd(4'h1, 32'h333333A3, "R1 word1 queue9");
    rd(4'h0, 32'h33333335, "R1 word0 queue0");
    rd(4'h5, 32'h00000008, "R3 uo word1 queue17 overflow");
    rd(4'h4, 32'h0, "R3 uo word0");
    rd(4'h7, 32'h00000020, "R1 upper full");
  endtask

  task automatic t_fields;
    fwr(10, 4'h5);
    rd(4'h9, 32'h00000500, "R5 queue10 field");
    fwr(11, 4'hF);
    rd(4'h9, 32'h0000F500, "R5 queue11 keeps queue10");
    fwr(0, 4'hF);
    rd(4'h8, 32'h00000007, "R6 queue0 low bits only");
    @(negedge clk); ctl_set = 1; @(negedge clk); ctl_set = 0;
    rd(4'h8, 32'h0000000F, "R6 control set");
    fwr(0, 4'h0);
    rd(4'h8, 32'h00000008, "R6 control kept");
  endtask

  task automatic t_sources;
    // queue10 code 5 = not nearly empty
    wr(4'hE, 32'hFFFFFFFF);
    set_nib(10, 4'h1);
    rd(4'hE, 32'h00000400, "R4 not-nearly-empty queue10");
    wr(4'hE, 32'h00000400);
    idle(3);
    rd(4'hE, 32'h0, "R10 level does not re-set");
    // queue3 code 2 = nearly full
    fwr(3, 4'h2);
    wr(4'hE, 32'hFFFFFFFF);
    set_nib(3, 4'h4);
    rd(4'hE, 32'h00000008, "R4 nearly-full queue3");
    // queue20 code 4 = not empty
    fwr(20, 4'h4);
    wr(4'hE, 32'hFFFFFFFF);
    set_nib(20, 4'h2);
    rd(4'hE, 32'h00100000, "R4 not-empty queue20");
    // queue31 code 3 = full
    fwr(31, 4'h3);
    wr(4'hE, 32'hFFFFFFFF);
    set_nib(31, 4'h8);
    rd(4'hE, 32'h80000000, "R4 full queue31");
  endtask

  task automatic t_clear_enable;
    set_nib(3, 4'h3);
    set_nib(3, 4'h4);
    rd(4'hE, 32'h80000008, "R8 two bits latched");
    wr(4'hE, 32'h00000008);
    rd(4'hE, 32'h80000000, "R8 partial clear");
    idle(2);
    check("R9 no enable", {31'b0, irq_lo}, 32'h0);
    wr(4'hC, 32'h80000000);
    idle(2);
    check("R9 enabled bit raises line", {31'b0, irq_lo}, 32'h1);
    wr(4'hC, 32'h00000020);
    idle(2);
    check("R9 other enable keeps low", {31'b0, irq_lo}, 32'h0);
    wr(4'hC, 32'h80000000);
    wr(4'hE, 32'h80000000);
    idle(2);
    check("R9 cleared bit drops line", {31'b0, irq_lo}, 32'h0);
  endtask

  task automatic t_upper;
    wr(4'hF, 32'hFFFFFFFF);
    @(negedge clk); up_full[9] = 1'b1; idle(4);
    rd(4'hF, 32'h0, "R7 full has no effect");
    @(negedge clk); up_ne[4] = 1'b0; idle(4);
    rd(4'hF, 32'h0, "R7 falling nearly empty");
    @(negedge clk); up_ne[4] = 1'b1; idle(4);
    rd(4'hF, 32'h00000010, "R7 rising nearly empty");
    wr(4'hD, 32'h00000010);
    idle(2);
    check("R9 upper line", {31'b0, irq_up}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    t_reset();
    t_status();
    t_fields();
    t_sources();
    t_clear_enable();
    t_upper();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule